// File: doc/BRIEF.md
# Dual-Section I2C Control Register Slave

This block is a bus-side I2C slave that owns the control state of two independent output sections. Each section has one 8-bit register. The host writes a register to set that section's enable, voltage select, line-drop compensation, tone arming, continuous-tone and current-limit mode. It reads the register back to get three of those bits echoed, together with the live over-temperature and overload flags.

Both wires are resynchronized to the system clock, so SCL edges and START/STOP conditions are found on the synchronized copies. The system clock should run at least eight times faster than SCL. A supply-undervoltage input clears both registers and silences the slave completely for as long as it is asserted.

Top module: `dual_sect_i2c_ctrl`

## Requirements
- R1: The 7-bit address 000100s selects section A and 000101s selects section B, where s must equal that section's strap input. The eighth bit is R/W, with 1 meaning read. A matching address is acknowledged by SDA being pulled low during the ninth SCL pulse.
- R2: An address outside both pairs, or one whose last bit disagrees with the strap, gets no acknowledge. Bytes that follow before the next START are neither acknowledged nor stored.
- R3: A written data byte maps to the outputs as follows: bit 7 is clamp_static, bit 6 is tone_arm, bit 5 is tone_cont, bit 4 is line_comp, bit 3 is hv_sel and bit 2 is pwr_en. Bits 1:0 are ignored.
- R4: A write to one section leaves the other section's outputs unchanged.
- R5: A read byte, sent MSB first, is {0,0,0,line_comp,hv_sel,pwr_en,ovt_flag,ovl_flag} of the addressed section. The two flags are taken live when the byte is loaded.
- R6: In a read, a master acknowledge makes the slave send a further byte, with freshly sampled flags. A master not-acknowledge ends the read, and the slave leaves SDA released.
- R7: After reset all control outputs are 0 and sda_oe is 0.
- R8: While uvlo is high both registers are held at 0, and the slave gives no acknowledge to anything. The registers stay 0 after uvlo falls until they are written.
- R9: A STOP returns the slave to idle with SDA released. A repeated START begins a new address phase.
- R10: The slave begins to pull SDA low only while SCL is low.
- R11: Every data byte of a write is acknowledged and stored in turn, so the last byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Address strap per section (bit 0 = A) |
| uvlo | input | 1 | Supply undervoltage lockout |
| ovt_flag | input | 2 | Live over-temperature flag per section |
| ovl_flag | input | 2 | Live overload flag per section |
| pwr_en | output | 2 | Section power enable |
| hv_sel | output | 2 | High-voltage select |
| line_comp | output | 2 | Line-drop compensation |
| tone_arm | output | 2 | Tone output armed |
| tone_cont | output | 2 | Continuous tone |
| clamp_static | output | 2 | Static current clamp (0 = pulsed) |

## Verification
The hardest case to reach is a read that keeps going after a master acknowledge while the fault flags change partway through. The second byte must carry the new flags, and the first byte must not. The bench drives the eight data bits of the first byte by hand, toggles the flags, and only then clocks the acknowledge bit. Two further cases are mixed with valid traffic and checked at the outputs: a strap-mismatched address followed by a stray data byte, and a write attempted under undervoltage lockout.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int SEC_N     = 2;
  localparam int CTL_W     = 6;
  localparam int BYTE_BITS = 8;
  localparam logic [4:0] ADDR_HI = 5'b00010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } bus_st_t;

  typedef struct packed {
    logic clamp_static;
    logic tone_arm;
    logic tone_cont;
    logic line_comp;
    logic hv_sel;
    logic pwr_en;
  } sect_ctl_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_sect_fsm.sv
module i2c_sect_fsm
  import dsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             uvlo,
  input  logic [SEC_N-1:0] strap,
  input  logic [7:0]       rd_byte,
  output logic             rd_sel,
  output logic             sda_oe,
  output logic             wr_en,
  output logic             wr_sel,
  output logic [CTL_W-1:0] wr_ctl
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

  bus_st_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]     sh_q, sh_d;
  logic           sec_q, sec_d, rw_q, rw_d, oe_q, oe_d, more_q, more_d, wr_q, wr_d;
  logic           addr_hit;

  assign addr_hit = (sh_q[7:3] == ADDR_HI) && (sh_q[1] == strap[sh_q[2]]);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; sec_d = sec_q;
    rw_d = rw_q; oe_d = oe_q; more_d = more_q; wr_d = 1'b0;
    if (uvlo || stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (st_q == ST_WDAT) begin
              wr_d = 1'b1; oe_d = 1'b1; st_d = ST_WACK;
            end else if (addr_hit) begin
              sec_d = sh_q[2]; rw_d = sh_q[0]; oe_d = 1'b1; st_d = ST_AACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (st_q == ST_AACK && rw_q) begin
              sh_d = rd_byte; oe_d = ~rd_byte[7]; st_d = ST_RDAT;
            end else begin
              oe_d = 1'b0; st_d = ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              oe_d = 1'b0; st_d = ST_RACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_d = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              sh_d = rd_byte; oe_d = ~rd_byte[7]; cnt_d = '0; st_d = ST_RDAT;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; sec_q <= 1'b0;
      rw_q <= 1'b0; oe_q <= 1'b0; more_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; sec_q <= sec_d;
      rw_q <= rw_d; oe_q <= oe_d; more_q <= more_d; wr_q <= wr_d;
    end
  end

  assign rd_sel = sec_q;
  assign sda_oe = oe_q;
  assign wr_en  = wr_q;
  assign wr_sel = sec_q;
  assign wr_ctl = sh_q[7:8-CTL_W];

  AST_UVLO_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) uvlo |=> !oe_q); // R8
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe_q) |-> !scl_s); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> (st_q == ST_IDLE && !oe_q)); // R9
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_q |=> !wr_q); // R11
endmodule

// File: rtl/sect_regs.sv
module sect_regs
  import dsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTL_W-1:0] wr_ctl,
  input  logic             rd_sel,
  input  logic [SEC_N-1:0] ovt_flag,
  input  logic [SEC_N-1:0] ovl_flag,
  output sect_ctl_t        ctl_o [SEC_N],
  output logic [7:0]       rd_byte
);
  sect_ctl_t ctl_q [SEC_N];
  sect_ctl_t ctl_d [SEC_N];

  for (genvar g = 0; g < SEC_N; g++) begin : g_sect
    always_comb begin
      ctl_d[g] = ctl_q[g];
      if (uvlo) ctl_d[g] = '0;
      else if (wr_en && wr_sel == 1'(g)) ctl_d[g] = sect_ctl_t'(wr_ctl);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[g] <= '0;
      else        ctl_q[g] <= ctl_d[g];
    end
    assign ctl_o[g] = ctl_q[g];
    AST_ZERO_IN_UVLO: assert property (@(posedge clk) disable iff (!rst_n) uvlo |=> (ctl_q[g] == '0)); // R8
  end

  assign rd_byte = {3'b000, ctl_q[rd_sel].line_comp, ctl_q[rd_sel].hv_sel,
                    ctl_q[rd_sel].pwr_en, ovt_flag[rd_sel], ovl_flag[rd_sel]};

  AST_OTHER_SECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !uvlo) |=> $stable(ctl_q[1])); // R4
endmodule

// File: rtl/dual_sect_i2c_ctrl.sv
module dual_sect_i2c_ctrl
  import dsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap,
  input  logic       uvlo,
  input  logic [1:0] ovt_flag,
  input  logic [1:0] ovl_flag,
  output logic [1:0] pwr_en,
  output logic [1:0] hv_sel,
  output logic [1:0] line_comp,
  output logic [1:0] tone_arm,
  output logic [1:0] tone_cont,
  output logic [1:0] clamp_static
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             rd_sel, wr_en, wr_sel;
  logic [CTL_W-1:0] wr_ctl;
  logic [7:0]       rd_byte;
  sect_ctl_t        ctl [SEC_N];

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_sect_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .uvlo(uvlo), .strap(strap), .rd_byte(rd_byte),
    .rd_sel(rd_sel), .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_ctl(wr_ctl)
  );

  sect_regs u_regs (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_ctl(wr_ctl), .rd_sel(rd_sel), .ovt_flag(ovt_flag), .ovl_flag(ovl_flag),
    .ctl_o(ctl), .rd_byte(rd_byte)
  );

  for (genvar g = 0; g < SEC_N; g++) begin : g_out
    assign pwr_en[g]       = ctl[g].pwr_en;
    assign hv_sel[g]       = ctl[g].hv_sel;
    assign line_comp[g]    = ctl[g].line_comp;
    assign tone_arm[g]     = ctl[g].tone_arm;
    assign tone_cont[g]    = ctl[g].tone_cont;
    assign clamp_static[g] = ctl[g].clamp_static;
  end
endmodule

// File: tb/dual_sect_i2c_ctrl_test.sv
module dual_sect_i2c_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, uvlo = 1'b0;
  logic [1:0] strap = 2'b10, ovt = 2'b00, ovl = 2'b00;
  logic sda_oe;
  logic [1:0] pwr_en, hv_sel, line_comp, tone_arm, tone_cont, clamp_static;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic [5:0] exp_ctl [2];
  logic cmp_on = 1'b0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_sect_i2c_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .uvlo(uvlo), .ovt_flag(ovt), .ovl_flag(ovl),
    .pwr_en(pwr_en), .hv_sel(hv_sel), .line_comp(line_comp), .tone_arm(tone_arm),
    .tone_cont(tone_cont), .clamp_static(clamp_static)
  );

  function automatic logic [5:0] act_ctl(int i);
    return {clamp_static[i], tone_arm[i], tone_cont[i], line_comp[i], hv_sel[i], pwr_en[i]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model comparison on every clock, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (cmp_on) begin
      chk("R3/R4 section A outputs", {2'b00, act_ctl(0)}, {2'b00, exp_ctl[0]});
      chk("R3/R4 section B outputs", {2'b00, act_ctl(1)}, {2'b00, exp_ctl[1]});
    end
    if (rst_n && scl && scl_prev)
      chk("R10 SDA drive stable while SCL high", {7'd0, sda_oe}, {7'd0, oe_prev});
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic m_start;
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask
  task automatic m_stop;
    sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask
  task automatic m_bit(input logic b, output logic s);
    sda_m = b; hold(Q); scl = 1'b1; hold(Q); s = sda_bus; hold(Q); scl = 1'b0; hold(Q);
  endtask
  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic m_rbits(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input logic exp_ack, string req);
    logic ack;
    cmp_on = 1'b0;
    m_start;
    m_wbyte({a, 1'b0}, ack);
    chk({req, " address ack"}, {7'd0, ack}, {7'd0, exp_ack});
    m_wbyte(d, ack);
    chk({req, " data ack"}, {7'd0, ack}, {7'd0, exp_ack});
    m_stop;
    if (exp_ack) exp_ctl[a[1]] = d[7:2];
    hold(2);
    cmp_on = 1'b1;
  endtask

  initial begin
    logic ack, s;
    logic [7:0] rd;
    exp_ctl[0] = '0; exp_ctl[1] = '0;
    hold(3);
    chk("R7 reset outputs", {act_ctl(1)[1:0], act_ctl(0)}, 8'h00);
    chk("R7 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    hold(4);
    cmp_on = 1'b1;

    // R1/R3: section A, strap low, test bits set but ignored
    wr_txn(7'b0001000, 8'hAF, 1'b1, "R1 R3 write A");
    // R1/R4: section B, strap high
    wr_txn(7'b0001011, 8'h54, 1'b1, "R1 R4 write B");

    // R2: strap disagrees, then stray data byte with no START
    cmp_on = 1'b0;
    m_start;
    m_wbyte({7'b0001001, 1'b0}, ack);
    chk("R2 strap mismatch nack", {7'd0, ack}, 8'h00);
    m_wbyte(8'hFF, ack);
    chk("R2 stray byte nack", {7'd0, ack}, 8'h00);
    m_stop;
    hold(2); cmp_on = 1'b1;
    wr_txn(7'b1000000, 8'hFF, 1'b0, "R2 foreign address");

    // R5/R6: read A, flags change before the master ack
    ovt = 2'b01; ovl = 2'b00;
    cmp_on = 1'b0;
    m_start;
    m_wbyte({7'b0001000, 1'b1}, ack);
    chk("R1 read address ack", {7'd0, ack}, 8'h01);
    m_rbits(rd);
    chk("R5 first read byte", rd, 8'h0E);
    ovt = 2'b00; ovl = 2'b01;
    m_bit(1'b0, s);
    m_rbits(rd);
    chk("R6 second byte after master ack", rd, 8'h0D);
    m_bit(1'b1, s);
    chk("R6 bus released after nack", {7'd0, sda_bus}, 8'h01);
    m_stop;
    chk("R9 released after stop", {7'd0, sda_oe}, 8'h00);
    hold(2); cmp_on = 1'b1;
    ovl = 2'b00;

    // R11: two data bytes to B, last wins
    cmp_on = 1'b0;
    m_start;
    m_wbyte({7'b0001011, 1'b0}, ack);
    m_wbyte(8'h20, ack);
    chk("R11 first data ack", {7'd0, ack}, 8'h01);
    m_wbyte(8'hC8, ack);
    chk("R11 second data ack", {7'd0, ack}, 8'h01);
    m_stop;
    exp_ctl[1] = 6'b110010;
    hold(2); cmp_on = 1'b1;

    // R9: write then repeated START read
    cmp_on = 1'b0;
    m_start;
    m_wbyte({7'b0001000, 1'b0}, ack);
    m_wbyte(8'h10, ack);
    exp_ctl[0] = 6'b000100;
    m_start;
    m_wbyte({7'b0001000, 1'b1}, ack);
    chk("R9 repeated start ack", {7'd0, ack}, 8'h01);
    m_rbits(rd);
    chk("R9 read after repeated start", rd, 8'h10);
    m_bit(1'b1, s);
    m_stop;
    hold(2); cmp_on = 1'b1;

    // R1: other strap value for section A
    strap = 2'b11;
    wr_txn(7'b0001000, 8'hFF, 1'b0, "R1 old A code nack");
    wr_txn(7'b0001001, 8'h04, 1'b1, "R1 A strap high");

    // R8: undervoltage lockout
    cmp_on = 1'b0;
    uvlo = 1'b1;
    exp_ctl[0] = '0; exp_ctl[1] = '0;
    hold(3); cmp_on = 1'b1;
    wr_txn(7'b0001001, 8'hFC, 1'b0, "R8 no ack in uvlo");
    uvlo = 1'b0;
    hold(3);
    cmp_on = 1'b0;
    m_start;
    m_wbyte({7'b0001011, 1'b1}, ack);
    chk("R8 ack after uvlo ends", {7'd0, ack}, 8'h01);
    m_rbits(rd);
    chk("R8 registers zero after uvlo", rd, 8'h00);
    m_bit(1'b1, s);
    m_stop;
    hold(2); cmp_on = 1'b1;
    hold(20);
    finish_sim;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim;
  end
endmodule